// File: doc/BRIEF.md
# TDM Time Slot Assigner

This block serves one side of a serial time-division-multiplexed voice interface. It follows the bit clock and the frame sync, and it numbers every bit position of the frame. From that number it opens two windows. The first is a capture window during the programmed input slot, where serial input bits are gathered into a word. The second is a drive window during the programmed output slot, where a result word is shifted out and the output enable is raised. Outside the drive window the output enable stays low, so a shared line can be wired as a tristate.

The bit clock is not used as a clock. It reaches the block as two one-cycle enables, one for the rising edge and one for the falling edge, both in the system clock domain. The coding direction sets the slot sizes. When compressing, the input carries 8-bit PCM and the output carries 4-bit ADPCM. When expanding, the two sizes are swapped. The companding law sets how many byte slots fit in a frame. A forced mode pins both slot numbers to zero so that no configuration is needed.

Top module: `tdm_slot_assigner`

## Requirements
- R1: After reset `dout_oe`, `dout` and `cap_valid` are 0 and `cap_word` is 0.
- R2: Bit 0 of a frame starts at the first `bclk_rise` that follows a `bclk_fall` on which `fsync` is 1. Each later `bclk_rise` advances the position by one. Before the first such sync no window opens. A new sync restarts the count from bit 0.
- R3: With `compress`=1 the input slot is 8 bits and the output slot is 4 bits. With `compress`=0 the input slot is 4 bits and the output slot is 8 bits. Slot k of width w covers frame bits k*w to k*w+w-1.
- R4: With `ulaw`=1 a frame holds 32 byte slots. With `ulaw`=0 it holds 64 byte slots. Either law gives 64 nibble slots. A slot number at or beyond the count for its width never opens a window.
- R5: `din` is sampled on each `bclk_fall` inside the input window, most significant bit first. In the cycle after the `bclk_fall` of the last bit, `cap_valid` is 1 for one cycle and `cap_word` holds the word. A 4-bit word sits in bits 3:0, with bits 7:4 at zero.
- R6: On each `bclk_rise` inside the output window, `dout_oe` is 1 and `dout` carries the next bit, two cycles after the `bclk_rise` cycle. The bits go out most significant first, taken from `res_word` (bits 3:0 for a 4-bit slot), and `res_word` is sampled when the first bit is driven. Outside the window `dout_oe` and `dout` are 0.
- R7: While `idle` is 1, `dout_oe` is 0 from the next cycle on and no word is captured.
- R8: With `hw_mode`=1 both slot numbers act as 0, whatever `in_slot` and `out_slot` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bclk_rise | input | 1 | One-cycle pulse per bit clock rising edge |
| bclk_fall | input | 1 | One-cycle pulse per bit clock falling edge |
| fsync | input | 1 | Frame sync level, looked at on `bclk_fall` |
| din | input | 1 | Serial input data |
| compress | input | 1 | 1 = compress (8-bit in, 4-bit out), 0 = expand |
| ulaw | input | 1 | 1 = µ-law frame (32 byte slots), 0 = A-law (64) |
| idle | input | 1 | Channel idle: no drive, no capture |
| hw_mode | input | 1 | Force both slot numbers to 0 |
| in_slot | input | 6 | Input slot number |
| out_slot | input | 6 | Output slot number |
| res_word | input | 8 | Word to transmit in the output slot |
| cap_word | output | 8 | Last captured input word |
| cap_valid | output | 1 | One-cycle strobe for a new `cap_word` |
| dout | output | 1 | Serial output data |
| dout_oe | output | 1 | Output enable for `dout` |

## Verification
Several stimulus patterns are applied, and each one separates a different set of faults. A compress frame and an expand frame use different nonzero slots and asymmetric data and result words, so swapped widths, shifted slot starts, reversed bit order and a wrong nibble placement all show up. Slot 40 is tried under both laws: it is out of range for µ-law byte slots but valid for A-law, which tests the slot-count limit in both directions. Slot 63 tests the top nibble slot. Further runs cover bit clocks with no sync, a sync arriving mid-frame, forced mode with nonzero slot numbers, and idle. They show whether counting, restart, slot forcing and output suppression are wired to the right controls.

// File: rtl/tsa_pkg.sv
// Shared constants and helpers for the TDM time slot assigner.
package tsa_pkg;
    localparam int BYTE_BITS = 8;   // PCM slot size
    localparam int NIB_BITS  = 4;   // ADPCM slot size
    localparam int OFS_W     = 3;   // bit offset inside a slot

    // Width of a slot in bits for the given size select.
    function automatic logic [OFS_W:0] slot_bits(input logic wide);
        return wide ? (OFS_W+1)'(BYTE_BITS) : (OFS_W+1)'(NIB_BITS);
    endfunction

    // Larger of two integers, used for derived widths.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/tsa_bit_counter.sv
// Frame bit position counter.
// Arms on a falling bit-clock edge that sees frame sync high. The next rising
// edge becomes bit 0. After that each rising edge advances the position.
// At the last representable position the counter stops and stays out of all
// windows until the next sync.
// Assumes bclk_rise and bclk_fall are single-cycle pulses that never coincide.
module tsa_bit_counter #(
    parameter int POS_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_rise,
    input  logic             bclk_fall,
    input  logic             fsync,
    output logic             running,
    output logic [POS_W-1:0] bitpos,
    output logic             step
);
    localparam logic [POS_W-1:0] POS_LAST = '1;

    logic armed;

    // Track sync arming, frame position and the running flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            running <= 1'b0;
            bitpos  <= '0;
        end else begin
            if (bclk_fall && fsync) begin
                armed <= 1'b1;
            end
            if (bclk_rise) begin
                if (armed) begin
                    armed   <= 1'b0;
                    running <= 1'b1;
                    bitpos  <= '0;
                end else if (running && bitpos != POS_LAST) begin
                    bitpos <= bitpos + 1'b1;
                end else begin
                    running <= 1'b0;
                end
            end
        end
    end

    // Delayed rising-edge strobe: the driver acts once the position is updated.
    always_ff @(posedge clk) begin
        if (!rst_n) step <= 1'b0;
        else        step <= bclk_rise;
    end
endmodule

// File: rtl/tsa_window.sv
// Slot window decoder.
// Reports whether the current frame position lies inside the given slot,
// together with the offset and the first/last bit flags. A slot number at or
// beyond the slot count never matches.
// Purely combinational. Assumes slot_cnt fits in CNT_W bits.
module tsa_window #(
    parameter int POS_W  = 9,
    parameter int SLOT_W = 6,
    parameter int CNT_W  = 7
) (
    input  logic                      running,
    input  logic [POS_W-1:0]          bitpos,
    input  logic [SLOT_W-1:0]         slot,
    input  logic                      wide,
    input  logic [CNT_W-1:0]          slot_cnt,
    output logic                      active,
    output logic [tsa_pkg::OFS_W-1:0] offset,
    output logic                      first,
    output logic                      last
);
    import tsa_pkg::*;

    localparam int AW = imax(POS_W, SLOT_W + OFS_W) + 1;

    logic [AW-1:0]    slot_ext;
    logic [AW-1:0]    pos_ext;
    logic [AW-1:0]    start;
    logic [AW-1:0]    rel;
    logic [OFS_W:0]   width;
    logic             in_range;

    // Slot start, position relative to it and the window decision.
    always_comb begin
        width    = slot_bits(wide);
        slot_ext = AW'(slot);
        pos_ext  = AW'(bitpos);
        start    = wide ? (slot_ext << 3) : (slot_ext << 2);
        rel      = pos_ext - start;
        in_range = (CNT_W'(slot) < slot_cnt);
        active   = running && in_range && (pos_ext >= start) && (rel < AW'(width));
        offset   = rel[OFS_W-1:0];
        first    = (offset == '0);
        last     = (offset == OFS_W'(width - 1'b1));
    end
endmodule

// File: rtl/tsa_capture.sv
// Input word capture.
// Shifts din in, most significant bit first, on falling bit-clock edges inside
// the input window. On the last bit of the slot it presents the word with a
// one-cycle valid strobe. A 4-bit word is right-aligned with zero fill.
// Assumes falling-edge pulses are at least two cycles apart.
module tsa_capture #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_fall,
    input  logic              active,
    input  logic              last,
    input  logic              wide,
    input  logic              idle,
    input  logic              din,
    output logic [WORD_W-1:0] cap_word,
    output logic              cap_valid
);
    import tsa_pkg::*;

    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] nxt;

    // Next shift register contents with the new bit appended.
    always_comb nxt = {shreg[WORD_W-2:0], din};

    // Shift, latch the finished word and pulse valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            cap_word  <= '0;
            cap_valid <= 1'b0;
        end else begin
            cap_valid <= 1'b0;
            if (bclk_fall && active && !idle) begin
                shreg <= nxt;
                if (last) begin
                    cap_word  <= wide ? nxt : {{(WORD_W-NIB_BITS){1'b0}}, nxt[NIB_BITS-1:0]};
                    cap_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tsa_driver.sv
// Output word driver.
// On each rising-edge step inside the output window it drives the next bit,
// most significant first, and raises the output enable. res_word is loaded on
// the first bit. A 4-bit slot sends res_word's low nibble. Outside the window,
// or while idle, the enable and data are held low.
module tsa_driver #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              active,
    input  logic              first,
    input  logic              wide,
    input  logic              idle,
    input  logic [WORD_W-1:0] res_word,
    output logic              dout,
    output logic              dout_oe
);
    import tsa_pkg::*;

    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] load;

    // Left-aligned word for the coming slot.
    always_comb load = wide ? res_word : {res_word[NIB_BITS-1:0], {(WORD_W-NIB_BITS){1'b0}}};

    // Drive the serial output and its enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            dout    <= 1'b0;
            dout_oe <= 1'b0;
        end else if (idle) begin
            dout    <= 1'b0;
            dout_oe <= 1'b0;
        end else if (step) begin
            if (active) begin
                if (first) begin
                    dout  <= load[WORD_W-1];
                    shreg <= load << 1;
                end else begin
                    dout  <= shreg[WORD_W-1];
                    shreg <= shreg << 1;
                end
                dout_oe <= 1'b1;
            end else begin
                dout    <= 1'b0;
                dout_oe <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tdm_slot_assigner.sv
// TDM time slot assigner, top level.
// Counts frame bit positions from the sync, opens an input capture window and
// an output drive window at the programmed slots, and picks the slot widths
// from the coding direction and the slot counts from the companding law.
// Assumes bit-clock edge pulses are single cycles, at least two cycles apart.
module tdm_slot_assigner #(
    parameter int SLOT_W        = 6,
    parameter int MU_BYTE_SLOTS = 32,
    parameter int A_BYTE_SLOTS  = 64,
    parameter int NIB_SLOTS     = 64,
    parameter int WORD_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_rise,
    input  logic              bclk_fall,
    input  logic              fsync,
    input  logic              din,
    input  logic              compress,
    input  logic              ulaw,
    input  logic              idle,
    input  logic              hw_mode,
    input  logic [SLOT_W-1:0] in_slot,
    input  logic [SLOT_W-1:0] out_slot,
    input  logic [WORD_W-1:0] res_word,
    output logic [WORD_W-1:0] cap_word,
    output logic              cap_valid,
    output logic              dout,
    output logic              dout_oe
);
    import tsa_pkg::*;

    localparam int FRAME_MAX = imax(imax(MU_BYTE_SLOTS, A_BYTE_SLOTS) * BYTE_BITS,
                                    NIB_SLOTS * NIB_BITS);
    localparam int POS_W     = $clog2(FRAME_MAX);
    localparam int CNT_W     = imax($clog2(imax(imax(MU_BYTE_SLOTS, A_BYTE_SLOTS), NIB_SLOTS) + 1),
                                    SLOT_W + 1);
    localparam logic [CNT_W-1:0] MU_CNT  = CNT_W'(MU_BYTE_SLOTS);
    localparam logic [CNT_W-1:0] A_CNT   = CNT_W'(A_BYTE_SLOTS);
    localparam logic [CNT_W-1:0] NIB_CNT = CNT_W'(NIB_SLOTS);

    logic              running;
    logic              step;
    logic [POS_W-1:0]  bitpos;
    logic [SLOT_W-1:0] eff_in;
    logic [SLOT_W-1:0] eff_out;
    logic              in_wide;
    logic              out_wide;
    logic [CNT_W-1:0]  in_cnt;
    logic [CNT_W-1:0]  out_cnt;
    logic              in_act, in_first, in_last;
    logic              out_act, out_first, out_last;
    logic [OFS_W-1:0]  in_ofs, out_ofs;
    logic              unused_ok;

    // Slot numbers, widths and counts chosen by mode and law.
    always_comb begin
        eff_in   = hw_mode ? '0 : in_slot;
        eff_out  = hw_mode ? '0 : out_slot;
        in_wide  = compress;
        out_wide = !compress;
        in_cnt   = in_wide  ? (ulaw ? MU_CNT : A_CNT) : NIB_CNT;
        out_cnt  = out_wide ? (ulaw ? MU_CNT : A_CNT) : NIB_CNT;
    end

    // Decoder outputs that no consumer needs.
    always_comb unused_ok = &{1'b0, in_first, out_last, in_ofs, out_ofs};

    tsa_bit_counter #(.POS_W(POS_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
        .fsync(fsync), .running(running), .bitpos(bitpos), .step(step)
    );

    tsa_window #(.POS_W(POS_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_in_win (
        .running(running), .bitpos(bitpos), .slot(eff_in), .wide(in_wide),
        .slot_cnt(in_cnt), .active(in_act), .offset(in_ofs), .first(in_first),
        .last(in_last)
    );

    tsa_window #(.POS_W(POS_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_out_win (
        .running(running), .bitpos(bitpos), .slot(eff_out), .wide(out_wide),
        .slot_cnt(out_cnt), .active(out_act), .offset(out_ofs), .first(out_first),
        .last(out_last)
    );

    tsa_capture #(.WORD_W(WORD_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .bclk_fall(bclk_fall), .active(in_act),
        .last(in_last), .wide(in_wide), .idle(idle), .din(din),
        .cap_word(cap_word), .cap_valid(cap_valid)
    );

    tsa_driver #(.WORD_W(WORD_W)) u_drv (
        .clk(clk), .rst_n(rst_n), .step(step), .active(out_act),
        .first(out_first), .wide(out_wide), .idle(idle), .res_word(res_word),
        .dout(dout), .dout_oe(dout_oe)
    );
endmodule

// File: rtl/tsa_checker.sv
// Protocol checks for the time slot assigner, bound to its top module.
module tsa_checker (
    input logic clk,
    input logic rst_n,
    input logic bclk_rise,
    input logic bclk_fall,
    input logic idle,
    input logic cap_valid,
    input logic dout,
    input logic dout_oe
);
    // R7: idle removes the drive by the next cycle.
    assert_idle_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> !dout_oe);

    // R7: no capture strobe follows an idle cycle.
    assert_idle_no_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> !$past(idle));

    // R6: data is low whenever the drive is off.
    assert_dout_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> !dout);

    // R6: the enable moves only two cycles after a rising edge, or on idle.
    assert_oe_timing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout_oe) |-> ($past(bclk_rise, 2) || $past(idle)));

    // R5: the valid strobe is a single cycle.
    assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> !cap_valid);

    // R5: the valid strobe follows a falling bit-clock edge.
    assert_valid_after_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> $past(bclk_fall));
endmodule

bind tdm_slot_assigner tsa_checker u_tsa_checker (
    .clk(clk), .rst_n(rst_n), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
    .idle(idle), .cap_valid(cap_valid), .dout(dout), .dout_oe(dout_oe)
);

// File: tb/tdm_slot_assigner_bench.sv
// Directed bench for the TDM time slot assigner.
module tdm_slot_assigner_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk_rise = 1'b0, bclk_fall = 1'b0, fsync = 1'b0, din = 1'b0;
    logic       compress = 1'b0, ulaw = 1'b0, idle = 1'b0, hw_mode = 1'b0;
    logic [5:0] in_slot = '0, out_slot = '0;
    logic [7:0] res_word = '0;
    logic [7:0] cap_word;
    logic       cap_valid, dout, dout_oe;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [15:0] pat = 16'hB38D;

    always #5 clk = ~clk;

    tdm_slot_assigner u_tdm_slot_assigner (
        .clk(clk), .rst_n(rst_n), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
        .fsync(fsync), .din(din), .compress(compress), .ulaw(ulaw), .idle(idle),
        .hw_mode(hw_mode), .in_slot(in_slot), .out_slot(out_slot),
        .res_word(res_word), .cap_word(cap_word), .cap_valid(cap_valid),
        .dout(dout), .dout_oe(dout_oe)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Window model straight from the requirements (R3, R4, R8).
    function automatic bit in_win(input bit wide, input int slot, input int b, output int ofs);
        int w = wide ? 8 : 4;
        int n = wide ? (ulaw ? 32 : 64) : 64;
        int s = hw_mode ? 0 : slot;
        ofs = b - s * w;
        return (s < n) && (b >= s * w) && (b < s * w + w);
    endfunction

    task automatic start_frame();
        fsync = 1'b1; bclk_fall = 1'b1;
        @(negedge clk);
        fsync = 1'b0; bclk_fall = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Runs bit periods and checks every output against the model.
    task automatic run_bits(input int nbits, input bit synced, input string tag);
        logic [7:0] acc = '0;
        if (synced) start_frame();
        for (int b = 0; b < nbits; b++) begin
            int io, oo;
            bit ia, oa, ev;
            int ow, iw;
            logic [7:0] ew;
            iw = compress ? 8 : 4;
            ow = compress ? 4 : 8;
            ia = synced && in_win(compress, int'(in_slot), b, io) && !idle;
            oa = synced && in_win(!compress, int'(out_slot), b, oo) && !idle;
            bclk_rise = 1'b1;
            @(negedge clk);
            bclk_rise = 1'b0;
            @(negedge clk);
            chk(tag, "dout_oe", int'(dout_oe), int'(oa));
            chk(tag, "dout", int'(dout), oa ? int'(res_word[ow - 1 - oo]) : 0);
            chk(tag, "cap_valid idle", int'(cap_valid), 0);
            din = pat[b % 16];
            if (ia) acc = {acc[6:0], din};
            ev = ia && (io == iw - 1);
            ew = (iw == 8) ? acc : {4'h0, acc[3:0]};
            @(negedge clk);
            bclk_fall = 1'b1;
            @(negedge clk);
            bclk_fall = 1'b0;
            chk(tag, "cap_valid", int'(cap_valid), int'(ev));
            if (ev) chk(tag, "cap_word", int'(cap_word), int'(ew));
            @(negedge clk);
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic config_ch(input bit c, input bit u, input bit h, input bit i,
                             input logic [5:0] is, input logic [5:0] os, input logic [7:0] r);
        compress = c; ulaw = u; hw_mode = h; idle = i;
        in_slot = is; out_slot = os; res_word = r;
    endtask

    task automatic test_reset_R1();
        chk("R1", "dout_oe", int'(dout_oe), 0);
        chk("R1", "dout", int'(dout), 0);
        chk("R1", "cap_valid", int'(cap_valid), 0);
        chk("R1", "cap_word", int'(cap_word), 0);
    endtask

    task automatic test_no_sync_R2();
        config_ch(1, 1, 0, 0, 6'd0, 6'd0, 8'hFF);
        run_bits(12, 1'b0, "R2 no sync");
    endtask

    task automatic test_compress_R3();
        config_ch(1, 1, 0, 0, 6'd2, 6'd5, 8'hA6);
        run_bits(30, 1'b1, "R3 R5 R6 compress");
    endtask

    task automatic test_expand_R3();
        pat = 16'h6C35;
        config_ch(0, 0, 0, 0, 6'd3, 6'd1, 8'h5C);
        run_bits(20, 1'b1, "R3 R5 R6 expand");
    endtask

    task automatic test_hw_mode_R8();
        config_ch(1, 1, 1, 0, 6'd7, 6'd9, 8'h3B);
        run_bits(12, 1'b1, "R8 forced slots");
        hw_mode = 1'b0;
    endtask

    task automatic test_idle_R7();
        config_ch(0, 1, 0, 1, 6'd0, 6'd0, 8'hE7);
        run_bits(12, 1'b1, "R7 idle");
        idle = 1'b0;
    endtask

    task automatic test_range_R4();
        pat = 16'hD2A9;
        config_ch(1, 1, 0, 0, 6'd40, 6'd63, 8'h0B);
        run_bits(330, 1'b1, "R4 ulaw slot40");
        config_ch(1, 0, 0, 0, 6'd40, 6'd63, 8'h0B);
        run_bits(330, 1'b1, "R4 alaw slot40");
    endtask

    task automatic test_restart_R2();
        config_ch(0, 1, 0, 0, 6'd1, 6'd0, 8'h96);
        run_bits(3, 1'b1, "R2 partial");
        run_bits(16, 1'b1, "R2 restart");
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset_R1();
        test_no_sync_R2();
        test_compress_R3();
        test_expand_R3();
        test_hw_mode_R8();
        test_idle_R7();
        test_range_R4();
        test_restart_R2();
        finish_run();
    end
endmodule